// File: doc/BRIEF.md
# Interrupt-Triggered Descriptor Transfer Engine

This engine serves peripheral service requests without CPU help. Each channel has a request input, a termination input and a per-channel service-enable bit. When a channel with service enabled raises its request, the engine reads that channel's four-word descriptor from memory. The descriptor holds a control word, a remaining-count word, an I/O pointer and a buffer pointer. The engine then moves one byte or one word between the two pointers, advances the pointers that are not frozen, decrements the count, writes the three updated words back and closes the service with a two-bit status code.

A service ends in one of three ways. On the quiet path the count is still nonzero: the engine pulses an acknowledge that clears the peripheral's request, and no interrupt is raised. If the count runs out, service is disabled and a normal interrupt is raised. If the peripheral asks to stop and stopping is allowed, no data moves and a normal interrupt is raised. A channel whose enable bit is clear passes its request straight to the interrupt output. When several channels are eligible, the lowest index goes first; this is a plain selection, not a priority scheme.

Descriptors sit at `DESC_BASE + 8*channel` as byte addresses. The words are: control at +0, count at +2, I/O pointer at +4 and buffer pointer at +6. Each word is 16 bits, low byte at the lower address.

Top module: `dxfer_engine`

## Requirements
- R1: A service starts only for a channel whose request is high, whose enable bit is 1 and which is not held. When the enable bit is 0, a high request drives that channel's `irq_o` high and starts no memory access.
- R2: Every service begins with four word reads, in order, of the channel's descriptor at offsets +0, +2, +4 and +6 from `DESC_BASE + 8*channel`.
- R3: If the channel's `term_i` is high and control bit 4 (stop-enable) is 1, the service performs no memory write. It sets that channel's status to 11, raises `irq_o` and gives no acknowledge. If control bit 4 is 0, `term_i` is ignored.
- R4: Control bit 0 selects the direction. With 0, the engine reads at the I/O pointer and writes at the buffer pointer. With 1, it reads at the buffer pointer and writes at the I/O pointer.
- R5: Control bit 1 selects the width. With 0, one byte moves and an advancing pointer steps by 1. With 1, a 16-bit word moves and an advancing pointer steps by 2.
- R6: Control bit 2 freezes the I/O pointer and control bit 3 freezes the buffer pointer. A pointer that is not frozen advances and wraps modulo 2^16.
- R7: Each service that moves data writes back the count minus one, wrapping modulo 2^16, so a count of 0 becomes FFFF. The updated I/O and buffer pointers go to their descriptor words.
- R8: If the decremented count is 0, the status becomes 01, the enable bit is cleared and `irq_o` is raised while the request stays high.
- R9: If the decremented count is nonzero, the status becomes 00 and `ack_o` pulses for one cycle on that channel only. No interrupt is raised.
- R10: After a stop or an exhausted count, the channel's request starts no new service until a pulse on `ise_set_i` sets the enable bit and clears the hold.
- R11: All descriptor writes finish before `done_o`. Each service gives exactly one one-cycle `done_o` pulse, and `busy_o` is low in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | NUM_CH | Peripheral service requests |
| term_i | input | NUM_CH | Peripheral stop requests |
| ise_set_i | input | NUM_CH | Pulse: set enable bit, clear hold |
| ack_o | output | NUM_CH | Request-clear pulse on the quiet path |
| irq_o | output | NUM_CH | Normal interrupt requests |
| ise_o | output | NUM_CH | Per-channel enable bits |
| status_o | output | 2*NUM_CH | Per-channel completion code, channel i at bits 2i+1:2i |
| busy_o | output | 1 | Service in progress |
| done_o | output | 1 | One-cycle end-of-service pulse |
| mem_re_o | output | 1 | Memory read strobe, data returned next cycle |
| mem_we_o | output | 1 | Memory write strobe |
| mem_wide_o | output | 1 | Access size: 1 word, 0 byte |
| mem_addr_o | output | WORD_W | Byte address |
| mem_wdata_o | output | WORD_W | Write data |
| mem_rdata_i | input | WORD_W | Read data |

## Verification
A wrong internal state shows up at the ports within one service of about a dozen cycles. A bad captured control word or pointer shows as a wrong source address in the first read after the descriptor fetch, or as a wrong destination address, width or data. A bad count or step shows in the descriptor words written back just before `done_o` and in the status code one cycle later. A bad enable or hold bit shows as a service that starts, or fails to start, while a request is held high, and as an `irq_o` level that differs from the expected one in the first idle cycle.

// File: rtl/dxfer_pkg.sv
package dxfer_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_F_CTL,
        ST_F_CNT,
        ST_F_IO,
        ST_F_BUF,
        ST_DECIDE,
        ST_MV_RD,
        ST_MV_WR,
        ST_WB_CNT,
        ST_WB_IO,
        ST_WB_BUF,
        ST_DONE
    } state_e;

    // control word bit positions
    localparam int CTL_DIR      = 0;
    localparam int CTL_WIDE     = 1;
    localparam int CTL_IO_HOLD  = 2;
    localparam int CTL_BUF_HOLD = 3;
    localparam int CTL_STOP_EN  = 4;
    localparam int CTL_W        = 5;

    localparam logic [1:0] STAT_RUN  = 2'b00;
    localparam logic [1:0] STAT_END  = 2'b01;
    localparam logic [1:0] STAT_STOP = 2'b11;

endpackage

// File: rtl/dxfer_pick.sv
module dxfer_pick #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  elig_i,
    output logic          hit_o,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        hit_o = |elig_i;
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (elig_i[i]) idx_o = IW'(i);
        end
    end
endmodule

// File: rtl/dxfer_ptr_step.sv
module dxfer_ptr_step #(
    parameter int W = 16
) (
    input  logic [W-1:0] ptr_i,
    input  logic         hold_i,
    input  logic         wide_i,
    output logic [W-1:0] ptr_o
);
    assign ptr_o = hold_i ? ptr_i : ptr_i + (wide_i ? W'(2) : W'(1));
endmodule

// File: rtl/dxfer_engine.sv
module dxfer_engine
    import dxfer_pkg::*;
#(
    parameter int                NUM_CH    = 4,
    parameter int                WORD_W    = 16,
    parameter logic [WORD_W-1:0] DESC_BASE = '0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_CH-1:0]     req_i,
    input  logic [NUM_CH-1:0]     term_i,
    input  logic [NUM_CH-1:0]     ise_set_i,
    output logic [NUM_CH-1:0]     ack_o,
    output logic [NUM_CH-1:0]     irq_o,
    output logic [NUM_CH-1:0]     ise_o,
    output logic [2*NUM_CH-1:0]   status_o,
    output logic                  busy_o,
    output logic                  done_o,
    output logic                  mem_re_o,
    output logic                  mem_we_o,
    output logic                  mem_wide_o,
    output logic [WORD_W-1:0]     mem_addr_o,
    output logic [WORD_W-1:0]     mem_wdata_o,
    input  logic [WORD_W-1:0]     mem_rdata_i
);
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int BYTE_W = WORD_W / 2;
    localparam int DSC_SH = 3;

    typedef struct packed {
        state_e                    state;
        logic [CH_W-1:0]           ch;
        logic [CTL_W-1:0]          ctl;
        logic [WORD_W-1:0]         cnt;
        logic [WORD_W-1:0]         io;
        logic [WORD_W-1:0]         bufp;
        logic                      stopped;
        logic [NUM_CH-1:0]         ise;
        logic [NUM_CH-1:0]         hold;
        logic [NUM_CH-1:0][1:0]    stat;
    } regs_t;

    regs_t r_q, r_d;

    logic [NUM_CH-1:0] elig_c;
    logic              hit_c;
    logic [CH_W-1:0]   pick_c;
    logic [WORD_W-1:0] io_next_c, buf_next_c, dbase_c;
    logic [NUM_CH-1:0] ack_c;

    assign elig_c  = req_i & r_q.ise & ~r_q.hold;
    assign dbase_c = DESC_BASE + (WORD_W'(r_q.ch) << DSC_SH);

    dxfer_pick #(.N(NUM_CH), .IW(CH_W)) u_pick (
        .elig_i (elig_c),
        .hit_o  (hit_c),
        .idx_o  (pick_c)
    );

    dxfer_ptr_step #(.W(WORD_W)) u_io_step (
        .ptr_i  (r_q.io),
        .hold_i (r_q.ctl[CTL_IO_HOLD]),
        .wide_i (r_q.ctl[CTL_WIDE]),
        .ptr_o  (io_next_c)
    );

    dxfer_ptr_step #(.W(WORD_W)) u_buf_step (
        .ptr_i  (r_q.bufp),
        .hold_i (r_q.ctl[CTL_BUF_HOLD]),
        .wide_i (r_q.ctl[CTL_WIDE]),
        .ptr_o  (buf_next_c)
    );

    always_comb begin
        r_d         = r_q;
        mem_re_o    = 1'b0;
        mem_we_o    = 1'b0;
        mem_wide_o  = 1'b1;
        mem_addr_o  = dbase_c;
        mem_wdata_o = '0;
        done_o      = 1'b0;
        ack_c       = '0;
        case (r_q.state)
            ST_IDLE: begin
                if (hit_c) begin
                    r_d.ch    = pick_c;
                    r_d.state = ST_F_CTL;
                end
            end
            ST_F_CTL: begin
                mem_re_o  = 1'b1;
                r_d.state = ST_F_CNT;
            end
            ST_F_CNT: begin
                mem_re_o   = 1'b1;
                mem_addr_o = dbase_c + WORD_W'(2);
                r_d.ctl    = mem_rdata_i[CTL_W-1:0];
                r_d.state  = ST_F_IO;
            end
            ST_F_IO: begin
                mem_re_o   = 1'b1;
                mem_addr_o = dbase_c + WORD_W'(4);
                r_d.cnt    = mem_rdata_i;
                r_d.state  = ST_F_BUF;
            end
            ST_F_BUF: begin
                mem_re_o   = 1'b1;
                mem_addr_o = dbase_c + WORD_W'(6);
                r_d.io     = mem_rdata_i;
                r_d.state  = ST_DECIDE;
            end
            ST_DECIDE: begin
                r_d.bufp    = mem_rdata_i;
                r_d.stopped = term_i[r_q.ch] && r_q.ctl[CTL_STOP_EN];
                r_d.state   = r_d.stopped ? ST_DONE : ST_MV_RD;
            end
            ST_MV_RD: begin
                mem_re_o   = 1'b1;
                mem_wide_o = r_q.ctl[CTL_WIDE];
                mem_addr_o = r_q.ctl[CTL_DIR] ? r_q.bufp : r_q.io;
                r_d.state  = ST_MV_WR;
            end
            ST_MV_WR: begin
                mem_we_o    = 1'b1;
                mem_wide_o  = r_q.ctl[CTL_WIDE];
                mem_addr_o  = r_q.ctl[CTL_DIR] ? r_q.io : r_q.bufp;
                mem_wdata_o = r_q.ctl[CTL_WIDE] ? mem_rdata_i
                            : {{BYTE_W{1'b0}}, mem_rdata_i[BYTE_W-1:0]};
                r_d.io      = io_next_c;
                r_d.bufp    = buf_next_c;
                r_d.cnt     = r_q.cnt - WORD_W'(1);
                r_d.state   = ST_WB_CNT;
            end
            ST_WB_CNT: begin
                mem_we_o    = 1'b1;
                mem_addr_o  = dbase_c + WORD_W'(2);
                mem_wdata_o = r_q.cnt;
                r_d.state   = ST_WB_IO;
            end
            ST_WB_IO: begin
                mem_we_o    = 1'b1;
                mem_addr_o  = dbase_c + WORD_W'(4);
                mem_wdata_o = r_q.io;
                r_d.state   = ST_WB_BUF;
            end
            ST_WB_BUF: begin
                mem_we_o    = 1'b1;
                mem_addr_o  = dbase_c + WORD_W'(6);
                mem_wdata_o = r_q.bufp;
                r_d.state   = ST_DONE;
            end
            ST_DONE: begin
                done_o    = 1'b1;
                r_d.state = ST_IDLE;
                if (r_q.stopped) begin
                    r_d.stat[r_q.ch] = STAT_STOP;
                    r_d.hold[r_q.ch] = 1'b1;
                end else if (r_q.cnt == '0) begin
                    r_d.stat[r_q.ch] = STAT_END;
                    r_d.ise[r_q.ch]  = 1'b0;
                    r_d.hold[r_q.ch] = 1'b1;
                end else begin
                    r_d.stat[r_q.ch] = STAT_RUN;
                    ack_c[r_q.ch]    = 1'b1;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
        for (int i = 0; i < NUM_CH; i++) begin
            if (ise_set_i[i]) begin
                r_d.ise[i]  = 1'b1;
                r_d.hold[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign busy_o = (r_q.state != ST_IDLE);
    assign ack_o  = ack_c;
    assign ise_o  = r_q.ise;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        assign status_o[2*g +: 2] = r_q.stat[g];
        assign irq_o[g] = req_i[g] & (~r_q.ise[g] | r_q.hold[g]);

        // exhausted count leaves the enable bit cleared unless software re-arms
        assert_exhaust_clears_ise_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (done_o && r_q.ch == CH_W'(g) && !r_q.stopped && r_q.cnt == '0 && !ise_set_i[g])
            |=> !ise_o[g]);
    end

    assert_start_eligible_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(elig_c != '0));

    assert_desc_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (mem_re_o && mem_wide_o && mem_addr_o == dbase_c));

    assert_ack_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack_o) && ((ack_o != '0) -> done_o));

    assert_done_ends_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);

endmodule

// File: tb/dxfer_engine_test.sv
module dxfer_engine_test;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;
    localparam int MSK = 1023;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NCH-1:0] req = '0, term = '0, ise_set = '0;
    logic [NCH-1:0] ack, irq, ise;
    logic [2*NCH-1:0] status;
    logic busy, done, mem_re, mem_we, mem_wide;
    logic [15:0] mem_addr, mem_wdata, mem_rdata;

    logic [7:0]  mem [0:MSK];
    logic [15:0] rd_log [0:7];
    logic [15:0] wr_log [0:7];
    int rd_n = 0, wr_n = 0;
    int n_chk = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dxfer_engine #(.NUM_CH(NCH)) uut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .term_i(term), .ise_set_i(ise_set),
        .ack_o(ack), .irq_o(irq), .ise_o(ise), .status_o(status), .busy_o(busy),
        .done_o(done), .mem_re_o(mem_re), .mem_we_o(mem_we), .mem_wide_o(mem_wide),
        .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
    );

    // memory model: one-cycle read latency, byte addressed
    always @(posedge clk) begin
        if (mem_re)
            mem_rdata <= mem_wide ? {mem[(mem_addr + 16'd1) & MSK], mem[mem_addr & MSK]}
                                  : {8'h00, mem[mem_addr & MSK]};
        if (mem_we) begin
            mem[mem_addr & MSK] <= mem_wdata[7:0];
            if (mem_wide) mem[(mem_addr + 16'd1) & MSK] <= mem_wdata[15:8];
        end
        if (!busy) begin
            rd_n <= 0; wr_n <= 0;
        end else begin
            if (mem_re && rd_n < 8) begin rd_log[rd_n] <= mem_addr; rd_n <= rd_n + 1; end
            if (mem_we && wr_n < 8) begin wr_log[wr_n] <= mem_addr; wr_n <= wr_n + 1; end
        end
    end

    function automatic logic [15:0] rd16(input logic [15:0] a);
        return {mem[(a + 16'd1) & MSK], mem[a & MSK]};
    endfunction

    function automatic logic [15:0] step(input logic [15:0] p, input logic hold, input logic wide);
        return hold ? p : p + (wide ? 16'd2 : 16'd1);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr16(input logic [15:0] a, input logic [15:0] v);
        mem[a & MSK] = v[7:0];
        mem[(a + 16'd1) & MSK] = v[15:8];
    endtask

    task automatic service(input int ch, input logic [4:0] ctl, input logic [15:0] cnt,
                           input logic [15:0] io, input logic [15:0] bp, input logic t);
        logic [15:0] db, src, dst, sdat, dold, e_cnt, e_io, e_bp, e_dst;
        logic stop, wide, quiet;
        int k;
        db = 16'(ch * 8);
        wr16(db, {11'd0, ctl}); wr16(db + 2, cnt); wr16(db + 4, io); wr16(db + 6, bp);
        wide = ctl[1];
        src  = ctl[0] ? bp : io;
        dst  = ctl[0] ? io : bp;
        sdat = 16'($urandom);
        dold = 16'($urandom);
        wr16(dst, dold);
        wr16(src, sdat);
        stop  = t && ctl[4];
        e_cnt = cnt - 16'd1;
        e_io  = step(io, ctl[2], wide);
        e_bp  = step(bp, ctl[3], wide);
        e_dst = wide ? sdat : {dold[15:8], sdat[7:0]};
        quiet = !stop && e_cnt != 16'd0;

        @(negedge clk);
        term[ch] = t; req[ch] = 1'b1;
        k = 0;
        while (!done && k < 64) begin @(negedge clk); k++; end
        chk("R11 done seen", 32'(done), 32'd1);
        chk("R2 desc read 0", 32'(rd_log[0]), 32'(db));
        chk("R2 desc read 1", 32'(rd_log[1]), 32'(db + 16'd2));
        chk("R2 desc read 2", 32'(rd_log[2]), 32'(db + 16'd4));
        chk("R2 desc read 3", 32'(rd_log[3]), 32'(db + 16'd6));
        chk("R9 ack", 32'(ack), quiet ? (32'd1 << ch) : 32'd0);
        if (stop) begin
            chk("R3 no writes", 32'(wr_n), 32'd0);
        end else begin
            chk("R4 src addr", 32'(rd_log[4]), 32'(src));
            chk("R4 dst addr", 32'(wr_log[0]), 32'(dst));
            chk("R11 writes before done", 32'(wr_n), 32'd4);
        end
        if (quiet) req[ch] = 1'b0;
        @(negedge clk);
        chk("R11 busy low after done", 32'(busy), 32'd0);
        if (stop) begin
            chk("R3 status", 32'(status[2*ch +: 2]), 32'd3);
            chk("R3 irq", 32'(irq[ch]), 32'd1);
            chk("R3 dst unchanged", 32'(rd16(dst)), 32'(dold));
            chk("R3 count unchanged", 32'(rd16(db + 2)), 32'(cnt));
        end else begin
            chk("R5 data moved", 32'(rd16(dst)), 32'(e_dst));
            chk("R7 count", 32'(rd16(db + 2)), 32'(e_cnt));
            chk("R6 io ptr", 32'(rd16(db + 4)), 32'(e_io));
            chk("R6 buf ptr", 32'(rd16(db + 6)), 32'(e_bp));
            if (quiet) begin
                chk("R9 status", 32'(status[2*ch +: 2]), 32'd0);
                chk("R9 irq", 32'(irq[ch]), 32'd0);
            end else begin
                chk("R8 status", 32'(status[2*ch +: 2]), 32'd1);
                chk("R8 ise cleared", 32'(ise[ch]), 32'd0);
                chk("R8 irq", 32'(irq[ch]), 32'd1);
            end
        end
        if (!quiet) begin
            repeat (5) @(negedge clk);
            chk("R10 held, no restart", 32'(busy), 32'd0);
            chk("R10 irq kept", 32'(irq[ch]), 32'd1);
            req[ch] = 1'b0;
            ise_set[ch] = 1'b1;
            @(negedge clk);
            ise_set[ch] = 1'b0;
            chk("R10 rearmed", 32'(ise[ch]), 32'd1);
        end
        term[ch] = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i <= MSK; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 reset busy", 32'(busy), 32'd0);
        chk("R8 reset status", 32'(status), 32'd0);
        chk("R1 reset ise", 32'(ise), 32'd0);

        // R1: enable bit clear, request goes to interrupt
        req[2] = 1'b1;
        repeat (4) @(negedge clk);
        chk("R1 irq passthrough", 32'(irq), 32'h4);
        chk("R1 no service", 32'(busy), 32'd0);
        chk("R1 no memory access", 32'(rd_n), 32'd0);
        req[2] = 1'b0;
        ise_set = '1;
        @(negedge clk);
        ise_set = '0;
        chk("R10 ise set", 32'(ise), 32'hF);

        // directed corners
        service(0, 5'b00000, 16'd2, 16'h0200, 16'h0100, 1'b0); // R4 io->buf byte quiet
        service(1, 5'b00011, 16'd3, 16'h0220, 16'h0140, 1'b0); // R5 buf->io word
        service(2, 5'b01110, 16'd5, 16'h0240, 16'h0160, 1'b0); // R6 both frozen
        service(3, 5'b00000, 16'd1, 16'h0260, 16'h0180, 1'b0); // R8 exhaust
        service(0, 5'b10000, 16'd4, 16'h0280, 16'h01A0, 1'b1); // R3 stop
        service(1, 5'b00010, 16'd4, 16'h02A0, 16'h01C0, 1'b1); // R3 term ignored
        service(2, 5'b00000, 16'd0, 16'h02C0, 16'hFFFF, 1'b0); // R7 count wrap, R6 ptr wrap

        for (int n = 0; n < 60; n++) begin
            service(int'($urandom % NCH), 5'($urandom),
                    16'($urandom % 3), 16'h0200 + 16'($urandom % 200),
                    16'h0100 + 16'($urandom % 200), ($urandom % 4) == 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule